// File: doc/BRIEF.md
# Calendar Time-of-Year Counter with Alarms

This unit keeps a wall-clock calendar (year, month, day, hour, minute, second, plus a sixteenth-of-a-second fraction) on a 32-bit register bus that takes word accesses only. A prescaler divides a reference strobe (nominally 32768 Hz) down to one step per second. The calendar rolls over using Gregorian month lengths, and any year divisible by 4 counts as a leap year.

Software loads the time through two set words and reads it through two live words. Three alarm words each hold a packed date and time. While the unit is running, an alarm whose fields equal the current time sets a sticky level interrupt. The unit runs only while two separate control bits are both set. In every other state the calendar holds, the live words read zero, and writes to the set words and alarm words are dropped.

Top module: `toy_unit`

## Requirements
- R1: The unit is active only when control bit 11 and control bit 8 are both 1. While it is inactive the calendar and the prescaler hold their values.
- R2: Live word 0 at 0x2C reads sub-second fraction [3:0], second [9:4], minute [15:10], hour [20:16], day [25:21] and month [31:26]. Months run from 1 to 12. The fraction is the prescaler count times 16 divided by DIV.
- R3: Live word 1 at 0x30 returns the year, zero-extended. Both live words read 0 while the unit is inactive.
- R4: A write to 0x24 loads second, minute, hour, day and month from the live word 0 positions, ignores bits [3:0], and restarts the prescaler at 0. A write to 0x28 loads the year from bits [15:0]. Both writes are dropped while the unit is inactive.
- R5: While the unit is active, the second advances on the DIV-th reference strobe counted from a prescaler restart. The advance lands on the clock edge that samples that strobe.
- R6: Seconds wrap at 59, minutes at 59 and hours at 23. Days wrap after 30 in April, June, September and November, after 28 in February (29 when year mod 4 is 0), and after 31 in other months. Month 12 wraps to 1 and increments the year.
- R7: Alarm words sit at 0x34, 0x38 and 0x3C. Each holds second [5:0], minute [11:6], hour [16:12], day [21:17], month [25:22] and year low bits [31:26]. Each alarm word reads back the last write the unit accepted, and writes to an alarm word are dropped while the unit is inactive.
- R8: An alarm matches when all its fields equal the current time, with only the low 6 bits of the year compared. The interrupt goes high one cycle after the match begins. Each match fires once, even if software clears the interrupt while the match still holds.
- R9: Alarms cannot fire while the unit is inactive. When the unit becomes active again, all three alarms re-arm, so an alarm that matches at that moment fires.
- R10: The interrupt stays high until software writes the control word at 0x40. If an alarm fires in the same cycle as that write, the interrupt stays set.
- R11: Reset clears the control word, all alarm words and the interrupt, and sets the time to year 0, January 1, 00:00:00. The control word reads back all 32 bits of its last write.
- R12: Any other address reads 0, the set words 0x24 and 0x28 included, and a write to any other address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| ref_tick | input | 1 | One-cycle strobe from the reference oscillator |
| bus_addr | input | ADDR_W | Byte address of the word access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, decoded combinationally from registers |
| irq | output | 1 | Sticky alarm interrupt |

## Verification
Reads are combinational from registers. A write or a prescaler step that is captured on one edge is therefore visible from that same edge onward, and the second advances on the edge that samples the DIV-th strobe. The interrupt is one register further along: it rises one edge after the calendar first equals an alarm, and it falls one edge after the control write. The bench drives inputs and samples all outputs at the falling edge, so every result is read half a cycle after the edge that produced it. The bench also compares read data and the interrupt against its own model on every cycle, and adds directed checks at the rollover, alarm and re-arm points, with hand-computed values.

// File: rtl/toy_pkg.sv
package toy_pkg;

  localparam int YEAR_W = 16;

  // bit positions in the live/set word 0
  localparam int LW_SEC = 4;
  localparam int LW_MIN = 10;
  localparam int LW_HR  = 16;
  localparam int LW_DAY = 21;
  localparam int LW_MON = 26;

  // bit positions in an alarm word
  localparam int AW_SEC = 0;
  localparam int AW_MIN = 6;
  localparam int AW_HR  = 12;
  localparam int AW_DAY = 17;
  localparam int AW_MON = 22;
  localparam int AW_YR  = 26;

  // compare key: {year[5:0], month, day, hour, minute, second}
  localparam int KEY_W = 34;

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [5:0]        mon;
    logic [4:0]        day;
    logic [4:0]        hour;
    logic [5:0]        min;
    logic [5:0]        sec;
  } cal_t;

  function automatic logic [4:0] month_len(input logic [5:0] mon,
                                           input logic [YEAR_W-1:0] yr);
    logic [4:0] len;
    case (mon)
      6'd2:                     len = (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      6'd4, 6'd6, 6'd9, 6'd11:  len = 5'd30;
      default:                  len = 5'd31;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/toy_prescaler.sv
module toy_prescaler #(
  parameter int DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       ref_tick,
  input  logic       restart,
  output logic       sec_tick,
  output logic [3:0] frac
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign sec_tick = en & ref_tick & (cnt_q == LAST);
  assign frac     = cnt_q[CW-1 -: 4];

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (restart)       cnt_d = '0;
      else if (ref_tick) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));

endmodule

// File: rtl/toy_calendar.sv
module toy_calendar
  import toy_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sec_tick,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [31:4]       lo_val,
  input  logic [YEAR_W-1:0] yr_val,
  output cal_t              cur
);
  cal_t t_q, t_d;

  always_comb begin
    t_d = t_q;
    if (en) begin
      if (ld_lo) begin
        t_d.sec  = lo_val[LW_MIN-1:LW_SEC];
        t_d.min  = lo_val[LW_HR-1:LW_MIN];
        t_d.hour = lo_val[LW_DAY-1:LW_HR];
        t_d.day  = lo_val[LW_MON-1:LW_DAY];
        t_d.mon  = lo_val[31:LW_MON];
      end else if (sec_tick) begin
        if (t_q.sec >= 6'd59) begin
          t_d.sec = '0;
          if (t_q.min >= 6'd59) begin
            t_d.min = '0;
            if (t_q.hour >= 5'd23) begin
              t_d.hour = '0;
              if (t_q.day >= month_len(t_q.mon, t_q.year)) begin
                t_d.day = 5'd1;
                if (t_q.mon >= 6'd12) begin
                  t_d.mon  = 6'd1;
                  t_d.year = t_q.year + 1'b1;
                end else begin
                  t_d.mon = t_q.mon + 1'b1;
                end
              end else begin
                t_d.day = t_q.day + 1'b1;
              end
            end else begin
              t_d.hour = t_q.hour + 1'b1;
            end
          end else begin
            t_d.min = t_q.min + 1'b1;
          end
        end else begin
          t_d.sec = t_q.sec + 1'b1;
        end
      end
      if (ld_hi) t_d.year = yr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q.year <= '0;
      t_q.mon  <= 6'd1;
      t_q.day  <= 5'd1;
      t_q.hour <= '0;
      t_q.min  <= '0;
      t_q.sec  <= '0;
    end else begin
      t_q <= t_d;
    end
  end

  assign cur = t_q;

  assert_hold_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(t_q));

  assert_sec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sec_tick && !ld_lo && t_q.sec == 6'd59) |=> (t_q.sec == 6'd0));

  assert_leap_day_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sec_tick && !ld_lo && t_q.mon == 6'd2 && t_q.day == 5'd28 &&
     t_q.year[1:0] == 2'b00 && t_q.hour == 5'd23 && t_q.min == 6'd59 &&
     t_q.sec == 6'd59) |=> (t_q.day == 5'd29));

endmodule

// File: rtl/toy_alarms.sv
module toy_alarms
  import toy_pkg::*;
#(
  parameter int N = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [N-1:0]        wr_sel,
  input  logic [31:0]         wdata,
  input  logic [KEY_W-1:0]    cur_key,
  output logic [N-1:0][31:0]  alarm_q,
  output logic [N-1:0]        fire
);
  for (genvar i = 0; i < N; i++) begin : g_alm
    logic [31:0]      val_d;
    logic             done_q, done_d;
    logic             match;
    logic [KEY_W-1:0] want;

    assign want = {alarm_q[i][31:AW_YR], 2'b00, alarm_q[i][AW_YR-1:AW_MON],
                   alarm_q[i][AW_MON-1:AW_DAY], alarm_q[i][AW_DAY-1:AW_HR],
                   alarm_q[i][AW_HR-1:AW_MIN], alarm_q[i][AW_MIN-1:AW_SEC]};
    assign match   = en & (want == cur_key);
    assign fire[i] = match & ~done_q;

    always_comb begin
      val_d  = (en && wr_sel[i]) ? wdata : alarm_q[i];
      done_d = match & ~wr_sel[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alarm_q[i] <= '0;
        done_q     <= 1'b0;
      end else begin
        alarm_q[i] <= val_d;
        done_q     <= done_d;
      end
    end

    assert_fire_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[i] && !wr_sel[i]) |=> !fire[i]);

    assert_keep_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(alarm_q[i]));
  end

endmodule

// File: rtl/toy_unit.sv
module toy_unit
  import toy_pkg::*;
#(
  parameter int DIV     = 32768,
  parameter int N_ALARM = 3,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_SET1 = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_LIV0 = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_LIV1 = ADDR_W'(8'h30);
  localparam int                A_ALM  = 'h34;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h40);
  localparam int RUN_BIT = 11;
  localparam int OSC_BIT = 8;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic [31:0] ctrl_q, ctrl_d;
  logic        irq_q, irq_d;
  logic        en, ctrl_wr, sec_tick;
  logic [3:0]  frac;
  logic [N_ALARM-1:0]       alm_wr, fire;
  logic [N_ALARM-1:0][31:0] alm_val;
  logic [KEY_W-1:0]         key;
  cal_t                     cur;

  assign en      = ctrl_q[RUN_BIT] & ctrl_q[OSC_BIT];
  assign ctrl_wr = bus_wr & (bus_addr == A_CTRL);

  for (genvar i = 0; i < N_ALARM; i++) begin : g_dec
    assign alm_wr[i] = bus_wr & (bus_addr == ADDR_W'(A_ALM + 4*i));
  end

  toy_prescaler #(.DIV(DIV)) u_pre (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .en       (en),
    .ref_tick (ref_tick),
    .restart  (bus_wr & (bus_addr == A_SET0)),
    .sec_tick (sec_tick),
    .frac     (frac)
  );

  toy_calendar u_cal (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .en       (en),
    .sec_tick (sec_tick),
    .ld_lo    (bus_wr & (bus_addr == A_SET0)),
    .ld_hi    (bus_wr & (bus_addr == A_SET1)),
    .lo_val   (bus_wdata[31:4]),
    .yr_val   (bus_wdata[YEAR_W-1:0]),
    .cur      (cur)
  );

  assign key = {cur.year[5:0], cur.mon, cur.day, cur.hour, cur.min, cur.sec};

  toy_alarms #(.N(N_ALARM)) u_alm (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .en      (en),
    .wr_sel  (alm_wr),
    .wdata   (bus_wdata),
    .cur_key (key),
    .alarm_q (alm_val),
    .fire    (fire)
  );

  always_comb begin
    ctrl_d = ctrl_wr ? bus_wdata : ctrl_q;
    irq_d  = (|fire) | (irq_q & ~ctrl_wr);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_LIV0 && en)
      bus_rdata = {cur.mon, cur.day, cur.hour, cur.min, cur.sec, frac};
    else if (bus_addr == A_LIV1 && en)
      bus_rdata = 32'(cur.year);
    else if (bus_addr == A_CTRL)
      bus_rdata = ctrl_q;
    for (int i = 0; i < N_ALARM; i++)
      if (bus_addr == ADDR_W'(A_ALM + 4*i)) bus_rdata = alm_val[i];
  end

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (irq_q && !ctrl_wr) |=> irq_q);

  assert_fire_sets_irq_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|fire) |=> irq_q);

  assert_quiet_off_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!en && !irq_q) |=> !irq_q);

endmodule

// File: tb/toy_unit_tb.sv
module toy_unit_tb;
  localparam int DIV = 16;
  localparam int NA  = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_tick;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  always #4 clk = ~clk;

  toy_unit #(.DIV(DIV), .N_ALARM(NA), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model state
  int m_cnt, m_sec, m_min, m_hr, m_day, m_mon, m_yr;
  bit [31:0] m_ctrl;
  bit [31:0] m_al [NA];
  bit        m_done [NA];
  bit        m_irq;
  // scratch
  bit        s_en, s_fire, s_m, s_irq;
  bit        s_done [NA];

  function automatic int mlen(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic bit m_match(bit [31:0] a);
    return a[31:26] == 6'(m_yr % 64) && int'(a[25:22]) == m_mon &&
           int'(a[21:17]) == m_day && int'(a[16:12]) == m_hr &&
           int'(a[11:6]) == m_min && int'(a[5:0]) == m_sec;
  endfunction

  function automatic bit [31:0] m_read(bit [7:0] a);
    bit e;
    e = m_ctrl[11] & m_ctrl[8];
    if (a == 8'h2C) return e ? {6'(m_mon), 5'(m_day), 5'(m_hr), 6'(m_min),
                                6'(m_sec), 4'(m_cnt * 16 / DIV)} : 32'd0;
    if (a == 8'h30) return e ? 32'(m_yr) : 32'd0;
    if (a == 8'h40) return m_ctrl;
    for (int i = 0; i < NA; i++) if (a == 8'(8'h34 + 4*i)) return m_al[i];
    return 32'd0;
  endfunction

  function automatic string rtag(bit [7:0] a);
    if (a == 8'h2C) return "R2";
    if (a == 8'h30) return "R3";
    if (a == 8'h40) return "R11";
    if (a >= 8'h34 && a <= 8'h3C) return "R7";
    return "R12";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0;
      m_ctrl = 0; m_irq = 0;
      for (int i = 0; i < NA; i++) begin m_al[i] = 0; m_done[i] = 0; end
    end else begin
      s_en = m_ctrl[11] & m_ctrl[8];
      s_fire = 0;
      for (int i = 0; i < NA; i++) begin
        s_m = s_en && m_match(m_al[i]);
        if (s_m && !m_done[i]) s_fire = 1;
        s_done[i] = s_m && !(bus_wr && bus_addr == 8'(8'h34 + 4*i));
      end
      s_irq = s_fire || (m_irq && !(bus_wr && bus_addr == 8'h40));
      if (s_en) begin
        for (int i = 0; i < NA; i++)
          if (bus_wr && bus_addr == 8'(8'h34 + 4*i)) m_al[i] = bus_wdata;
        if (bus_wr && bus_addr == 8'h24) begin
          m_sec = bus_wdata[9:4]; m_min = bus_wdata[15:10]; m_hr = bus_wdata[20:16];
          m_day = bus_wdata[25:21]; m_mon = bus_wdata[31:26]; m_cnt = 0;
        end else if (ref_tick) begin
          if (m_cnt == DIV - 1) begin
            m_cnt = 0;
            if (m_sec >= 59) begin
              m_sec = 0;
              if (m_min >= 59) begin
                m_min = 0;
                if (m_hr >= 23) begin
                  m_hr = 0;
                  if (m_day >= mlen(m_mon, m_yr)) begin
                    m_day = 1;
                    if (m_mon >= 12) begin m_mon = 1; m_yr = (m_yr + 1) % 65536; end
                    else m_mon++;
                  end else m_day++;
                end else m_hr++;
              end else m_min++;
            end else m_sec++;
          end else m_cnt++;
        end
        if (bus_wr && bus_addr == 8'h28) m_yr = bus_wdata[15:0];
      end
      if (bus_wr && bus_addr == 8'h40) m_ctrl = bus_wdata;
      m_irq = s_irq;
      for (int i = 0; i < NA; i++) m_done[i] = s_done[i];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock; compare against the model half a cycle after the edge
  task automatic cyc();
    @(negedge clk);
    if (rst_n) begin
      chk({rtag(bus_addr), " model read"}, bus_rdata, m_read(bus_addr));
      chk("R8 model irq", 32'(irq), 32'(m_irq));
    end
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic rd(bit [7:0] a, bit [31:0] exp, string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; ref_tick = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R11 reset values
    rd(8'h40, 0, "R11 ctrl reset");
    rd(8'h34, 0, "R11 alarm0 reset");
    rd(8'h3C, 0, "R11 alarm2 reset");
    chk("R11 irq reset", 32'(irq), 0);
    // R3 live words zero while inactive
    rd(8'h2C, 0, "R3 live0 off");
    rd(8'h30, 0, "R3 live1 off");
    // R7 alarm write dropped while inactive
    wr(8'h34, 32'h12345678);
    rd(8'h34, 0, "R7 alarm write dropped");
    // R4 time write dropped while inactive; R1 one bit alone is not enough
    wr(8'h24, 32'h0B97EFB0);
    ref_tick = 1'b1;
    wr(8'h40, 32'h800);
    repeat (20) cyc();
    rd(8'h2C, 0, "R1 single bit keeps unit off");
    wr(8'h40, 32'h900);
    rd(8'h2C, 32'h04200000, "R4 dropped write left Jan 1");
    rd(8'h40, 32'h900, "R11 ctrl readback");
    repeat (5) cyc();
    rd(8'h2C, 32'h04200005, "R2 fraction field");

    // R6 leap year February
    wr(8'h28, 2024);
    wr(8'h24, 32'h0B97EFB0);
    repeat (15) cyc();
    rd(8'h2C, 32'h0B97EFBF, "R5 no advance before DIV strobes");
    cyc();
    rd(8'h2C, 32'h0BA00000, "R6 leap Feb 29");
    // R6 common year February
    wr(8'h28, 2023);
    wr(8'h24, 32'h0B97EFB0);
    repeat (16) cyc();
    rd(8'h2C, 32'h0C200000, "R6 common year Mar 1");
    // R6 year end
    wr(8'h28, 63);
    wr(8'h24, 32'h33F7EFB0);
    repeat (16) cyc();
    rd(8'h2C, 32'h04200000, "R6 Dec 31 to Jan 1");
    rd(8'h30, 64, "R6 year increment");
    // R6 thirty-day month
    wr(8'h24, 32'h13D7EFB0);
    repeat (16) cyc();
    rd(8'h2C, 32'h14200000, "R6 Apr 30 to May 1");
    // R5 slower strobe pattern
    ref_tick = 1'b0;
    repeat (3) cyc();
    for (int k = 0; k < 40; k++) begin ref_tick = (k % 3 == 0); cyc(); end
    ref_tick = 1'b1;
    // R4 year write dropped while inactive
    wr(8'h40, 32'h100);
    wr(8'h28, 999);
    wr(8'h40, 32'h900);
    rd(8'h30, 64, "R4 year write dropped");

    // R8 alarm fires at the matching second
    wr(8'h28, 2024);
    wr(8'h24, 32'h0C200000);
    wr(8'h34, 32'hA0C20003);
    rd(8'h34, 32'hA0C20003, "R7 alarm readback");
    chk("R8 no early irq", 32'(irq), 0);
    repeat (40) cyc();
    chk("R8 irq before match", 32'(irq), 0);
    repeat (10) cyc();
    chk("R8 irq on match", 32'(irq), 1);
    repeat (20) cyc();
    chk("R10 irq sticky", 32'(irq), 1);
    wr(8'h40, 32'h900);
    chk("R10 irq cleared by ctrl write", 32'(irq), 0);

    // R8 once per match; R9 re-arm on enable
    ref_tick = 1'b0;
    wr(8'h24, 32'h0C200030);
    cyc();
    chk("R8 fires on loaded match", 32'(irq), 1);
    wr(8'h40, 32'h900);
    repeat (3) cyc();
    chk("R8 fires once per match", 32'(irq), 0);
    wr(8'h40, 32'h100);
    repeat (3) cyc();
    chk("R9 no irq while off", 32'(irq), 0);
    wr(8'h40, 32'h900);
    cyc();
    chk("R9 re-armed after enable", 32'(irq), 1);

    // R12 other addresses
    rd(8'h50, 0, "R12 unmapped read");
    rd(8'h24, 0, "R12 set word reads zero");
    wr(8'h30, 32'hFFFFFFFF);
    wr(8'h5C, 32'hFFFFFFFF);
    rd(8'h30, 2024, "R12 write elsewhere ignored");
    ref_tick = 1'b1;
    repeat (20) cyc();

    finished = 1;
    summary();
  end
endmodule